// File: doc/BRIEF.md
# Partitioned Min-Sum Check-Node Processor

This block performs the check-node update of a min-sum low-density parity-check decoder for a single parity-check row. The row's edges are divided into a configurable number of contiguous groups. Each group finds, on its own and in parallel with the others, the smallest and second-smallest incoming magnitude, the position of the smallest, and the XOR of the incoming signs. Groups do not exchange full-width minima. Each group passes only two single-bit signals to its neighbours. The first is a sign bit, forwarded along a chain. The second is a flag raised when the group's local minimum falls below a programmable threshold.

Each group forms its outgoing messages from its own minima. When an adjacent group raises its flag, the group clamps its outgoing magnitudes to the threshold. Outgoing signs follow the usual min-sum rule: the parity of all signs in the row, excluding the edge's own sign. A row of messages is presented with a valid strobe. The corresponding outgoing row appears on the registered output one clock later.

Top module: `split_row_cnode`

## Requirements
- R1: While `rst` is high and at the first clock after it, `out_valid` is 0 and `msg_out` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `msg_out` then carries the result computed from the `msg_in` and `thresh` values presented in that earlier cycle.
- R3: In a cycle with `in_valid` low, `msg_out` keeps its previous value and `out_valid` is 0 in the following cycle.
- R4: Edge e occupies bits [6e+5:6e] of `msg_in` and `msg_out`. Bit 6e+5 is the sign (1 = negative) and bits [6e+4:6e] are the unsigned magnitude. Group p owns edges p*ROW_W/NPART through (p+1)*ROW_W/NPART-1.
- R5: The output sign of every edge equals the XOR of all ROW_W input signs of the row, XORed with that edge's own input sign.
- R6: With no neighbour flag active, every edge except its group's minimum edge outputs the group's smallest input magnitude.
- R7: The group's minimum edge outputs the group's second-smallest magnitude. When several edges tie for the minimum, the lowest-numbered one is the minimum edge, so the tied edges all output that shared value.
- R8: Group p raises its flag when its smallest magnitude is strictly less than `thresh`. Only groups p-1 and p+1 act on that flag; groups further away are unaffected.
- R9: When at least one adjacent group's flag is raised, each output magnitude of the group becomes the smaller of its R6/R7 value and `thresh`.
- R10: With `thresh` equal to 0, no flag is ever raised and the output is the plain per-group min-sum result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row of incoming messages is present |
| msg_in | input | ROW_W*6 | Incoming sign-magnitude messages, one 6-bit slot per edge |
| thresh | input | 5 | Threshold for the neighbour flag and for clamping |
| out_valid | output | 1 | `msg_out` carries a fresh row |
| msg_out | output | ROW_W*6 | Outgoing sign-magnitude messages, one 6-bit slot per edge |

## Verification
The block has no state beyond its output register, so a wrong minimum, argmin position or flag shows up in the very row that triggered it. It appears one cycle after the strobe, as a wrong magnitude on some edge. A broken sign chain flips the sign of every edge in the groups downstream of the break. A broken flag path shows up only when the threshold lies between the minima of neighbouring groups. The directed cases therefore place a single small magnitude in one group and look at the groups one and two positions away.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int MAG_W = 5;
    localparam int MSG_W = MAG_W + 1;
    localparam int IDX_W = 8;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic sgn;
        mag_t mag;
    } msg_t;

    typedef struct packed {
        mag_t             min1;
        mag_t             min2;
        logic [IDX_W-1:0] idx;
        logic             sprod;
        logic             th_en;
    } part_stat_t;

    // Clamp a magnitude to the threshold when a neighbour flag is active.
    function automatic mag_t cap_mag(input mag_t m, input mag_t t, input logic en);
        return (en && (m > t)) ? t : m;
    endfunction

endpackage

// File: rtl/srt_part_scan.sv
module srt_part_scan
    import srt_pkg::*;
#(
    parameter int PART_W = 8
) (
    input  msg_t [PART_W-1:0] msgs,
    input  mag_t              thresh,
    output part_stat_t        stat
);

    always_comb begin
        mag_t             m1;
        mag_t             m2;
        logic [IDX_W-1:0] ix;
        logic             sp;
        m1 = '1;
        m2 = '1;
        ix = '0;
        sp = 1'b0;
        for (int i = 0; i < PART_W; i++) begin
            sp = sp ^ msgs[i].sgn;
            if (msgs[i].mag < m1) begin
                m2 = m1;
                m1 = msgs[i].mag;
                ix = IDX_W'(i);
            end else if (msgs[i].mag < m2) begin
                m2 = msgs[i].mag;
            end
        end
        stat.min1  = m1;
        stat.min2  = m2;
        stat.idx   = ix;
        stat.sprod = sp;
        stat.th_en = (m1 < thresh);
    end

endmodule

// File: rtl/srt_part_emit.sv
module srt_part_emit
    import srt_pkg::*;
#(
    parameter int PART_W = 8
) (
    input  msg_t [PART_W-1:0] msgs,
    input  part_stat_t        stat,
    input  mag_t              thresh,
    input  logic              nbr_th,
    input  logic              row_sign,
    output msg_t [PART_W-1:0] outs
);

    for (genvar e = 0; e < PART_W; e++) begin : g_edge
        mag_t base;
        assign base         = (stat.idx == IDX_W'(e)) ? stat.min2 : stat.min1;
        assign outs[e].mag  = cap_mag(base, thresh, nbr_th);
        assign outs[e].sgn  = row_sign ^ msgs[e].sgn;
    end

endmodule

// File: rtl/split_row_cnode.sv
module split_row_cnode
    import srt_pkg::*;
#(
    parameter int ROW_W = 32,
    parameter int NPART = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [ROW_W*MSG_W-1:0] msg_in,
    input  logic [MAG_W-1:0]       thresh,
    output logic                   out_valid,
    output logic [ROW_W*MSG_W-1:0] msg_out
);

    localparam int PART_W = ROW_W / NPART;

    msg_t [ROW_W-1:0] in_arr;
    msg_t [ROW_W-1:0] nxt_arr;
    part_stat_t       stat [NPART];
    logic [NPART-1:0] sp;
    logic [NPART-1:0] th_en;
    logic [NPART+1:0] th_ext;
    logic [NPART:0]   sgn_l;
    logic [NPART:0]   sgn_r;

    assign in_arr = msg_in;

    assign sgn_l[0]          = 1'b0;
    assign sgn_r[NPART]      = 1'b0;
    assign th_ext[0]         = 1'b0;
    assign th_ext[NPART+1]   = 1'b0;

    for (genvar p = 0; p < NPART; p++) begin : g_part
        srt_part_scan #(.PART_W(PART_W)) u_scan (
            .msgs   (in_arr[p*PART_W +: PART_W]),
            .thresh (thresh),
            .stat   (stat[p])
        );

        assign sp[p]          = stat[p].sprod;
        assign th_en[p]       = stat[p].th_en;
        assign th_ext[p+1]    = th_en[p];
        // One sign bit travels each way between adjacent groups.
        assign sgn_l[p+1]     = sgn_l[p] ^ sp[p];
        assign sgn_r[p]       = sgn_r[p+1] ^ sp[p];

        srt_part_emit #(.PART_W(PART_W)) u_emit (
            .msgs     (in_arr[p*PART_W +: PART_W]),
            .stat     (stat[p]),
            .thresh   (thresh),
            .nbr_th   (th_ext[p] | th_ext[p+2]),
            .row_sign (sgn_l[p] ^ sp[p] ^ sgn_r[p+1]),
            .outs     (nxt_arr[p*PART_W +: PART_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            msg_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                msg_out <= nxt_arr;
            end
        end
    end

endmodule

// File: rtl/srt_checker.sv
module srt_checker
    import srt_pkg::*;
#(
    parameter int ROW_W = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [ROW_W*MSG_W-1:0] msg_in,
    input logic                   out_valid,
    input logic [ROW_W*MSG_W-1:0] msg_out
);

    function automatic logic sign_par(input logic [ROW_W*MSG_W-1:0] v);
        logic r;
        r = 1'b0;
        for (int e = 0; e < ROW_W; e++) r = r ^ v[e*MSG_W + MAG_W];
        return r;
    endfunction

    function automatic mag_t min_mag(input logic [ROW_W*MSG_W-1:0] v);
        mag_t r;
        r = '1;
        for (int e = 0; e < ROW_W; e++)
            if (v[e*MSG_W +: MAG_W] < r) r = v[e*MSG_W +: MAG_W];
        return r;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                     // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                   // R3

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(msg_out));                             // R3

    AST_MAG_FLOOR: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (min_mag(msg_out) >= $past(min_mag(msg_in))));  // R9

    if (ROW_W % 2 == 0) begin : g_par
        AST_SIGN_PARITY: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (sign_par(msg_out) == $past(sign_par(msg_in)))); // R5
    end

endmodule

bind split_row_cnode srt_checker #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .msg_in    (msg_in),
    .out_valid (out_valid),
    .msg_out   (msg_out)
);

// File: tb/test_split_row_cnode.sv
`timescale 1ns/1ps
module test_split_row_cnode;

    localparam int ROW_W = 32;
    localparam int NPART = 4;
    localparam int PW    = ROW_W / NPART;
    localparam int BW    = ROW_W * 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [BW-1:0] msg_in;
    logic [4:0]    thresh;
    logic          out_valid;
    logic [BW-1:0] msg_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    split_row_cnode #(.ROW_W(ROW_W), .NPART(NPART)) i_split_row_cnode (
        .clk(clk), .rst(rst), .in_valid(in_valid), .msg_in(msg_in),
        .thresh(thresh), .out_valid(out_valid), .msg_out(msg_out)
    );

    function automatic logic [BW-1:0] model(input logic [BW-1:0] m, input logic [4:0] t);
        int   mn1 [NPART];
        int   mn2 [NPART];
        int   ix  [NPART];
        logic th  [NPART];
        logic tot;
        logic [BW-1:0] o;
        tot = 1'b0;
        for (int p = 0; p < NPART; p++) begin
            mn1[p] = 31; mn2[p] = 31; ix[p] = 0;
            for (int i = 0; i < PW; i++) begin
                int e, mg;
                e = p*PW + i;
                mg = int'(m[e*6 +: 5]);
                tot = tot ^ m[e*6+5];
                if (mg < mn1[p]) begin mn2[p] = mn1[p]; mn1[p] = mg; ix[p] = i; end
                else if (mg < mn2[p]) mn2[p] = mg;
            end
            th[p] = (mn1[p] < int'(t));
        end
        for (int e = 0; e < ROW_W; e++) begin
            int p, i, b;
            logic nb;
            p = e / PW; i = e % PW;
            b = (i == ix[p]) ? mn2[p] : mn1[p];
            nb = ((p > 0) && th[p-1]) || ((p < NPART-1) && th[p+1]);
            if (nb && b > int'(t)) b = int'(t);
            o[e*6 +: 6] = {tot ^ m[e*6+5], 5'(b)};
        end
        return o;
    endfunction

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one row, then sample the registered result one cycle later.
    task automatic apply(input string req, input logic [BW-1:0] m, input logic [4:0] t);
        @(negedge clk);
        in_valid = 1'b1; msg_in = m; thresh = t;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, BW'(out_valid), BW'(1));
        chk(req, msg_out, model(m, t));
    endtask

    function automatic logic [BW-1:0] fill(input logic [4:0] mg);
        logic [BW-1:0] r;
        for (int e = 0; e < ROW_W; e++) r[e*6 +: 6] = {1'b0, mg};
        return r;
    endfunction

    function automatic logic [BW-1:0] rnd_row();
        logic [BW-1:0] r;
        for (int e = 0; e < ROW_W; e++) r[e*6 +: 6] = 6'($urandom);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [BW-1:0] v;
        logic [BW-1:0] held;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; msg_in = '0; thresh = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", BW'(out_valid), BW'(0));
        chk("R1 data", msg_out, '0);
        rst = 1'b0;

        // R6 R5: uniform magnitudes, alternating signs
        v = fill(5'd20);
        for (int e = 0; e < ROW_W; e += 2) v[e*6+5] = 1'b1;
        apply("R6 uniform", v, 5'd0);

        // R4 R5: one negative edge flips every other sign
        v = fill(5'd9);
        v[5] = 1'b1;
        apply("R4 single sign", v, 5'd0);
        chk("R5 sign edge0", BW'(msg_out[5]), BW'(0));
        chk("R5 sign edge3", BW'(msg_out[3*6+5]), BW'(1));

        // R7: tie for minimum in group 0
        v = fill(5'd25);
        v[2*6 +: 5] = 5'd3;
        v[5*6 +: 5] = 5'd3;
        apply("R7 tie", v, 5'd0);
        chk("R7 tie edge2", BW'(msg_out[2*6 +: 5]), BW'(3));

        // R8 R9: small value in group 0 clamps group 1 only
        v = fill(5'd30);
        v[1*6 +: 5] = 5'd2;
        apply("R8 locality", v, 5'd10);
        chk("R9 clamp group1", BW'(msg_out[8*6 +: 5]), BW'(10));
        chk("R8 group2 untouched", BW'(msg_out[16*6 +: 5]), BW'(30));
        chk("R8 group0 own edge", BW'(msg_out[1*6 +: 5]), BW'(30));

        // R3: idle cycles leave output unchanged
        held = msg_out;
        @(negedge clk);
        msg_in = ~msg_in; thresh = 5'd31;
        @(negedge clk);
        chk("R3 idle valid", BW'(out_valid), BW'(0));
        chk("R3 hold", msg_out, held);

        // R10: zero threshold, random rows
        for (int k = 0; k < 20; k++) apply("R10 zero thresh", rnd_row(), 5'd0);

        // R9 R8 R5 R6 R7: random rows and thresholds
        for (int k = 0; k < 300; k++) apply("R9 random", rnd_row(), 5'($urandom));

        // R9: small threshold with low random magnitudes
        for (int k = 0; k < 50; k++) begin
            v = rnd_row();
            for (int e = 0; e < ROW_W; e++) v[e*6+4] = 1'b0;
            apply("R9 low mags", v, 5'($urandom_range(1, 15)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule